// File: doc/BRIEF.md
# Gate Enable and Battery Lockout Supervisor

This block decides, for each of a set of low-side driver channels, whether the channel's gate command is on. A channel is requested on by the serial control word or by its own parallel input, and the two sources are combined with a logical OR. The parallel inputs reach the commands through combinational logic only, so they take effect without any serial clock or chip-select activity. The serial control word comes from the serial shift and latch logic, which sits outside this block.

Two battery indications, over-voltage and under-voltage, come from analog comparators. Each passes through its own synchronizer. While either synchronized indication is high, every channel command is forced off and a suppress output tells the load-fault monitors to hold back their reports. When the indications clear, the commands follow their sources again. No software action is needed for that recovery.

The block also drives a composite fault flag as an open-drain, active-low output enable. The flag is pulled low at once by any load fault or battery fault. It stays pulled low after the fault goes away. It is released only on a chip-select falling-edge strobe that arrives while no fault is present. Battery faults affect only this flag and the suppress output. They are never placed in the serial fault word.

Top module: `gate_lockout_sup`

## Requirements
- R1: With no battery fault, `gate_cmd[i]` is 1 exactly when `ser_ctrl[i]` or `par_in[i]` is 1, where bit i is channel i.
- R2: A change on `par_in` reaches `gate_cmd` in the same cycle, with no clock edge and no `cs_fall` pulse.
- R3: Once `ov_in` has been high for `SYNC_STAGES` rising clock edges, all `gate_cmd` bits are 0 and `suppress` is 1. After fewer edges than that, the commands are not yet affected.
- R4: Once `uv_in` has been high for `SYNC_STAGES` rising clock edges, all `gate_cmd` bits are 0 and `suppress` is 1.
- R5: `suppress` is 0 once both battery inputs have been low for `SYNC_STAGES` edges, and the commands again follow R1.
- R6: `flag_oe_n` is 0 in the same cycle that any `load_flt` bit is 1, and is 0 whenever `suppress` is 1.
- R7: After all faults go away, `flag_oe_n` stays 0 until a `cs_fall` pulse is sampled. It is 1 after the rising edge that samples that pulse.
- R8: A `cs_fall` pulse sampled while any fault is present leaves `flag_oe_n` at 0.
- R9: While `rst_n` is 0, all `gate_cmd` bits are 0 and `flag_oe_n` is 1. After release, the synchronizers start clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_ctrl | input | NCH | Latched serial control word, 1 = on |
| par_in | input | NCH | Parallel channel requests, 1 = on |
| ov_in | input | 1 | Raw over-voltage comparator output |
| uv_in | input | 1 | Raw under-voltage comparator output |
| load_flt | input | NCH | Per-channel shorted/open load fault flags |
| cs_fall | input | 1 | One-cycle strobe marking a chip-select falling edge |
| gate_cmd | output | NCH | Per-channel gate commands |
| suppress | output | 1 | Battery fault present; holds back load-fault reports |
| flag_oe_n | output | 1 | Active-low enable of the open-drain fault flag pull-down |

## Verification
A release strobe on `cs_fall` can arrive in the same cycle that a fault first appears. The flag logic must then treat the fault as winning, because a release in that cycle would lose a live fault. The bench drives a load fault and the strobe together on one cycle and checks that the flag stays pulled low. It also drives the strobe while a synchronized over-voltage is present and checks the same result. It then releases the fault, sends a later strobe on its own, and checks that the flag is released only on that later strobe.

// File: rtl/gls_pkg.sv
package gls_pkg;
  localparam int unsigned NCH_DEF   = 4;
  localparam int unsigned SYNC_DEF  = 2;

  typedef enum logic [0:0] {
    FLAG_IDLE = 1'b0,
    FLAG_HELD = 1'b1
  } flag_state_e;
endpackage

// File: rtl/gls_sync.sv
module gls_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else if (STAGES == 1) chain <= d[b];
        else chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[LAST];
    end
  endgenerate
endmodule

// File: rtl/gls_combine.sv
module gls_combine #(
  parameter int unsigned NCH = 4
) (
  input  logic           rst_n,
  input  logic           bat_flt,
  input  logic [NCH-1:0] ser_ctrl,
  input  logic [NCH-1:0] par_in,
  output logic [NCH-1:0] gate_cmd
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic want;
      assign want        = ser_ctrl[c] | par_in[c];
      assign gate_cmd[c] = want & ~bat_flt & rst_n;
    end
  endgenerate
endmodule

// File: rtl/gls_flag.sv
module gls_flag
  import gls_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bat_flt,
  input  logic [NCH-1:0] load_flt,
  input  logic           cs_fall,
  output logic           flag_oe_n
);
  flag_state_e st_q, st_d;
  logic        fault_now;

  assign fault_now = bat_flt | (|load_flt);

  always_comb begin
    st_d = st_q;
    if (fault_now)    st_d = FLAG_HELD;
    else if (cs_fall) st_d = FLAG_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FLAG_IDLE;
    else        st_q <= st_d;
  end

  assign flag_oe_n = ~(rst_n & (fault_now | (st_q == FLAG_HELD)));
endmodule

// File: rtl/gate_lockout_sup.sv
module gate_lockout_sup
  import gls_pkg::*;
#(
  parameter int unsigned NCH         = NCH_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ser_ctrl,
  input  logic [NCH-1:0] par_in,
  input  logic           ov_in,
  input  logic           uv_in,
  input  logic [NCH-1:0] load_flt,
  input  logic           cs_fall,
  output logic [NCH-1:0] gate_cmd,
  output logic           suppress,
  output logic           flag_oe_n
);
  logic [1:0] bat_raw, bat_sync;
  logic       bat_flt;

  assign bat_raw = {uv_in, ov_in};

  gls_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bat_raw), .q(bat_sync)
  );

  assign bat_flt  = |bat_sync;
  assign suppress = bat_flt;

  gls_combine #(.NCH(NCH)) u_comb (
    .rst_n(rst_n), .bat_flt(bat_flt), .ser_ctrl(ser_ctrl),
    .par_in(par_in), .gate_cmd(gate_cmd)
  );

  gls_flag #(.NCH(NCH)) u_flag (
    .clk(clk), .rst_n(rst_n), .bat_flt(bat_flt), .load_flt(load_flt),
    .cs_fall(cs_fall), .flag_oe_n(flag_oe_n)
  );
endmodule

// File: rtl/gls_checker.sv
module gls_checker #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] par_in,
  input logic [NCH-1:0] load_flt,
  input logic           cs_fall,
  input logic [NCH-1:0] gate_cmd,
  input logic           suppress,
  input logic           flag_oe_n
);
  // R3 and R4: a battery fault leaves no channel on
  p_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> (gate_cmd == '0));

  // R1: a parallel request with no battery fault turns a channel on
  p_par_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!suppress && (par_in != '0)) |-> (gate_cmd != '0));

  // R6: a load fault pulls the flag low at once
  p_load_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_flt != '0) |-> !flag_oe_n);

  // R6: a battery fault pulls the flag low
  p_bat_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> !flag_oe_n);

  // R7: the flag is released only after a sampled strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!flag_oe_n) && !$past(cs_fall)) |-> !flag_oe_n);
endmodule

bind gate_lockout_sup gls_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_in(par_in), .load_flt(load_flt),
  .cs_fall(cs_fall), .gate_cmd(gate_cmd), .suppress(suppress),
  .flag_oe_n(flag_oe_n)
);

// File: tb/tb_gate_lockout_sup.sv
`timescale 1ns/1ps
module tb_gate_lockout_sup;
  localparam int NCH = 4;
  localparam int SYNC_STAGES = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] ser_ctrl, par_in, load_flt, gate_cmd;
  logic           ov_in, uv_in, cs_fall, suppress, flag_oe_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gate_lockout_sup #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) dut (
    .clk(clk), .rst_n(rst_n), .ser_ctrl(ser_ctrl), .par_in(par_in),
    .ov_in(ov_in), .uv_in(uv_in), .load_flt(load_flt), .cs_fall(cs_fall),
    .gate_cmd(gate_cmd), .suppress(suppress), .flag_oe_n(flag_oe_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ser_ctrl = 4'hF; par_in = 4'hF; load_flt = 4'h3;
    ov_in = 0; uv_in = 0; cs_fall = 0;
    cyc(2);
    chk("R9 gates off in reset", {4'h0, gate_cmd}, 8'h00);
    chk("R9 flag released in reset", {7'h0, flag_oe_n}, 8'h01);
    ser_ctrl = 0; par_in = 0; load_flt = 0;
    rst_n = 1'b1;
    cyc(1);
    chk("R9 sync clear after reset", {7'h0, suppress}, 8'h00);
  endtask

  task automatic t_union;
    ser_ctrl = 4'b0101; par_in = 4'b0011; #1;
    chk("R1 or of sources", {4'h0, gate_cmd}, 8'h07);
    ser_ctrl = 4'b1000; par_in = 4'b0000; #1;
    chk("R1 serial only", {4'h0, gate_cmd}, 8'h08);
    cyc(1);
  endtask

  task automatic t_parallel_rt;
    ser_ctrl = 0; par_in = 0; #1;
    chk("R2 all off", {4'h0, gate_cmd}, 8'h00);
    par_in = 4'b0100; #1;
    chk("R2 same-cycle parallel on", {4'h0, gate_cmd}, 8'h04);
    par_in = 0; #1;
    chk("R2 same-cycle parallel off", {4'h0, gate_cmd}, 8'h00);
    cyc(1);
  endtask

  task automatic t_battery(input bit use_ov, input string rq);
    ser_ctrl = 4'b1010; par_in = 4'b0001;
    if (use_ov) ov_in = 1; else uv_in = 1;
    cyc(SYNC_STAGES - 1);
    chk({rq, " not yet locked"}, {4'h0, gate_cmd}, 8'h0B);
    cyc(1);
    chk({rq, " gates forced off"}, {4'h0, gate_cmd}, 8'h00);
    chk({rq, " suppress high"}, {7'h0, suppress}, 8'h01);
    chk("R6 flag on battery fault", {7'h0, flag_oe_n}, 8'h00);
    ov_in = 0; uv_in = 0;
    cyc(SYNC_STAGES);
    chk("R5 suppress cleared", {7'h0, suppress}, 8'h00);
    chk("R5 gates recover", {4'h0, gate_cmd}, 8'h0B);
    chk("R7 flag held after battery fault", {7'h0, flag_oe_n}, 8'h00);
    cs_fall = 1; cyc(1); cs_fall = 0;
    chk("R7 flag released", {7'h0, flag_oe_n}, 8'h01);
    ser_ctrl = 0; par_in = 0;
  endtask

  task automatic t_flag_load;
    load_flt = 4'b0010; #1;
    chk("R6 immediate load flag", {7'h0, flag_oe_n}, 8'h00);
    cyc(1);
    load_flt = 0; cyc(3);
    chk("R7 hold without strobe", {7'h0, flag_oe_n}, 8'h00);
    cs_fall = 1; #1;
    chk("R7 not released before edge", {7'h0, flag_oe_n}, 8'h00);
    cyc(1); cs_fall = 0;
    chk("R7 released after strobe", {7'h0, flag_oe_n}, 8'h01);
  endtask

  task automatic t_same_cycle;
    load_flt = 4'b1000; cs_fall = 1;
    cyc(1);
    cs_fall = 0; load_flt = 0; #1;
    chk("R8 strobe with fault keeps flag", {7'h0, flag_oe_n}, 8'h00);
    ov_in = 1; cyc(SYNC_STAGES); ov_in = 0;
    cs_fall = 1; cyc(1); cs_fall = 0;
    chk("R8 strobe during battery fault", {7'h0, flag_oe_n}, 8'h00);
    cyc(SYNC_STAGES);
    cs_fall = 1; cyc(1); cs_fall = 0;
    chk("R8 later strobe releases", {7'h0, flag_oe_n}, 8'h01);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_union;
    t_parallel_rt;
    t_battery(1'b1, "R3");
    t_battery(1'b0, "R4");
    t_flag_load;
    t_same_cycle;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule